// File: doc/BRIEF.md
# Byte Register Memory

A small read/write store of four bytes held in flip-flops, addressed by a two-bit index. A write takes effect when the active-low write strobe is released. The strobe is sampled on the clock, and the clock edge that first sees it high after seeing it low commits the byte on the data input. A two-to-four decoder sends that byte to exactly one slot, and the other three slots keep their contents.

Reads are combinational. The address selects one slot through a byte-wide four-way multiplexer. While the read enable is high, that byte appears on the output and the output-enable flag is raised. While the read enable is low, the flag is dropped and the data lines are held at zero. The flag stands in for a three-state driver, so a surrounding bus can merge several such blocks without contention.

Top module: `byte_reg_mem`

## Requirements
- R1: While rst_ni is low, and after it is released, all four slots hold 0x00.
- R2: A write commits at the first rising clock edge where wr_ni is sampled 1 and the previous edge sampled it 0. That edge uses the addr_i and wdata_i values present at it, and the stored byte can be read in the cycle that follows.
- R3: wr_ni held low or held high across any number of edges writes nothing. Only its release commits, and it commits the data present at release. A single release gives exactly one write.
- R4: A write changes only the slot whose index equals addr_i (address value n selects slot n), and every other slot keeps its byte.
- R5: With rd_i = 1, oe_o = 1 and rdata_o equals the byte stored in slot addr_i, following addr_i within the same cycle.
- R6: With rd_i = 0, oe_o = 0 and rdata_o = 0x00 whatever is stored.
- R7: When a committing write and a read target the same slot in one cycle, the read shows the old byte before that edge and the new byte after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Slot index for both reads and writes |
| wdata_i | input | 8 | Byte to store |
| wr_ni | input | 1 | Write strobe, active low; release commits |
| rd_i | input | 1 | Read enable, active high |
| rdata_o | output | 8 | Selected byte, zero when not reading |
| oe_o | output | 1 | Output drive flag (0 means high impedance) |

## Verification
A read and a committing write can fall in the same cycle and target the same slot. The bench provokes this by holding rd_i high on one address while it releases wr_ni with new data on that address. It samples rdata_o twice: once before the committing edge, where it must still show the old byte, and once after it, where it must show the new byte. A strobe held low while the data changes, followed by a strobe held high while the data changes again, checks that only the release writes.

// File: rtl/brm_pkg.sv
package brm_pkg;
  localparam int unsigned DEF_ADDR_W = 2;
  localparam int unsigned DEF_DATA_W = 8;
endpackage

// File: rtl/brm_strobe_edge.sv
module brm_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ni,
  output logic we_o
);
  logic wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b1;
    else         wr_q <= wr_ni;
  end

  // release: low at last edge, high now
  assign we_o = ~wr_q & wr_ni;

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o); // R3
endmodule

// File: rtl/brm_addr_decode.sv
module brm_addr_decode #(
  parameter int unsigned ADDR_W = brm_pkg::DEF_ADDR_W,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic [DEPTH-1:0]  sel_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    assign sel_o[i] = en_i && (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/brm_byte_bank.sv
module brm_byte_bank #(
  parameter int unsigned ADDR_W = brm_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = brm_pkg::DEF_DATA_W,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [DEPTH-1:0]              sel_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DEPTH-1:0][DATA_W-1:0]  q_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= '0;
      else if (sel_i[i]) q_o[i] <= wdata_i;
    end

    AST_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_i[i] |=> $stable(q_o[i])); // R4
    AST_SLOT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_i[i] |=> (q_o[i] == $past(wdata_i))); // R2
  end
endmodule

// File: rtl/brm_read_port.sv
module brm_read_port #(
  parameter int unsigned ADDR_W = brm_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = brm_pkg::DEF_DATA_W,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [DEPTH-1:0][DATA_W-1:0]  q_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          rd_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic                          oe_o
);
  logic [DATA_W-1:0] mux_data;

  assign mux_data = q_i[addr_i];
  assign oe_o     = rd_i;
  assign rdata_o  = rd_i ? mux_data : '0;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (rdata_o == '0)); // R6
  AST_DRIVE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> (oe_o && rdata_o == q_i[addr_i])); // R5
endmodule

// File: rtl/byte_reg_mem.sv
module byte_reg_mem #(
  parameter int unsigned ADDR_W = brm_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = brm_pkg::DEF_DATA_W,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_ni,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              oe_o
);
  logic                         we;
  logic [DEPTH-1:0]             sel;
  logic [DEPTH-1:0][DATA_W-1:0] slots;

  brm_strobe_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_ni (wr_ni),
    .we_o  (we)
  );

  brm_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i),
    .en_i  (we),
    .sel_o (sel)
  );

  brm_byte_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .wdata_i(wdata_i),
    .q_o    (slots)
  );

  brm_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .q_i    (slots),
    .addr_i (addr_i),
    .rd_i   (rd_i),
    .rdata_o(rdata_o),
    .oe_o   (oe_o)
  );

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel) && (we == (sel != '0))); // R4
endmodule

// File: tb/byte_reg_mem_tb.sv
module byte_reg_mem_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_n = 1'b1;
  logic       rd = 1'b0;
  logic [7:0] rdata;
  logic       oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [4];

  always #5 clk = ~clk;

  byte_reg_mem u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_ni(wr_n), .rd_i(rd), .rdata_o(rdata), .oe_o(oe)
  );

  // {addr, data}
  localparam logic [9:0] VEC [6] = '{
    {2'd0, 8'h3C}, {2'd1, 8'hA5}, {2'd2, 8'hFF},
    {2'd3, 8'h01}, {2'd1, 8'h5A}, {2'd0, 8'h00}
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got oe=%0b data=%02h, want oe=%0b data=%02h",
               req, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_n = 1'b0; rd = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
    model[a] = d;
  endtask

  task automatic read_chk(input string req, input logic [1:0] a);
    @(negedge clk); addr = a; rd = 1'b1;
    #3 chk(req, {oe, rdata}, {1'b1, model[a]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset contents, R6 idle output
    #3 chk("R6 idle after reset", {oe, rdata}, 9'h000);
    for (int i = 0; i < 4; i++) read_chk("R1 reset clear", 2'(i));

    // table walk: R2 write, R5 read, R4 others intact
    for (int v = 0; v < 6; v++) begin
      do_write(VEC[v][9:8], VEC[v][7:0]);
      read_chk("R2 write lands", VEC[v][9:8]);
    end
    for (int i = 0; i < 4; i++) read_chk("R4 other slots kept", 2'(i));

    // R6 with nonzero content
    @(negedge clk); addr = 2'd1; rd = 1'b0;
    #3 chk("R6 read off", {oe, rdata}, 9'h000);

    // R5 address follows within the cycle
    @(negedge clk); rd = 1'b1; addr = 2'd2;
    #1 chk("R5 mux slot2", {oe, rdata}, {1'b1, model[2]});
    addr = 2'd3;
    #1 chk("R5 mux slot3", {oe, rdata}, {1'b1, model[3]});

    // R3 strobe held low with changing data: no write until release
    @(negedge clk); addr = 2'd2; wdata = 8'hAA; wr_n = 1'b0; rd = 1'b1;
    @(negedge clk); wdata = 8'hBB;
    @(negedge clk); #3 chk("R3 held low no write", {oe, rdata}, {1'b1, model[2]});
    wdata = 8'hC3;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); model[2] = 8'hC3;
    #3 chk("R3 release commits", {oe, rdata}, {1'b1, 8'hC3});
    // R3 held high: data changes, nothing written
    wdata = 8'h77;
    repeat (3) @(negedge clk);
    #3 chk("R3 held high no write", {oe, rdata}, {1'b1, 8'hC3});

    // R7 same-cycle read and write on slot 1
    @(negedge clk); addr = 2'd1; wdata = 8'h99; wr_n = 1'b0; rd = 1'b1;
    @(negedge clk); wr_n = 1'b1;
    #3 chk("R7 old byte before edge", {oe, rdata}, {1'b1, model[1]});
    @(negedge clk); model[1] = 8'h99;
    #3 chk("R7 new byte after edge", {oe, rdata}, {1'b1, 8'h99});
    for (int i = 0; i < 4; i++) read_chk("R4 after same-cycle", 2'(i));

    // R1 reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0; rd = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    for (int i = 0; i < 4; i++) read_chk("R1 reclear", 2'(i));

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule